// File: doc/BRIEF.md
# Two-Entry Elastic Pipeline Stage

This block is one register stage on a request/acknowledge channel that carries a data word of parameterised width. A producer offers a word by raising `in_req`; the word is taken on a clock edge where `in_ack` is also high. The stage then offers the word downstream on `out_req`/`out_dat`, and it is consumed on an edge where `out_ack` is high. A word accepted on one edge is visible at the output after that edge, so the forward latency is one cycle.

The stage has two storage slots and a five-state controller. In steady streaming one slot is in use. When the consumer stalls, the second slot absorbs the word that was already in flight. `in_ack` is decoded from the registered state alone, so a stall seen on `out_ack` reaches the producer one cycle later and never through a combinational path. The two slots are used in turn, and a word stays in the slot it was written to until it leaves. The output multiplexer follows whichever slot holds the oldest word.

Top module: `elastic_pair_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_req` is low and `in_ack` is high.
- R2: `in_ack` is low exactly when the stage holds two words and high when it holds zero or one.
- R3: `out_req` is high exactly when the stage holds at least one word.
- R4: A word accepted into an empty stage on a clock edge is presented on `out_dat` with `out_req` high directly after that edge (one-cycle latency).
- R5: Words leave in the order they were accepted. None is lost or duplicated, and the number held changes by (accepted minus delivered) on every edge.
- R6: While `out_req` is high and `out_ack` is low, `out_req` stays high and `out_dat` stays unchanged on the next cycle.
- R7: `in_ack` does not change when `out_ack` changes within a cycle. It depends only on registered state.
- R8: With `in_req` and `out_ack` held high, the stage accepts and delivers one word on every cycle and `in_ack` stays high.
- R9: A storage slot is written only on an upstream transfer (`in_req` and `in_ack` both high), and only the one free slot is written. `in_dat` has no effect in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_req | input | 1 | Producer offers a word |
| in_ack | output | 1 | Stage can take a word this cycle (registered) |
| in_dat | input | DATA_W | Offered word |
| out_req | output | 1 | Stage offers its oldest word |
| out_ack | input | 1 | Consumer takes the offered word |
| out_dat | output | DATA_W | Oldest held word |

## Verification
The stage is driven with random request and acknowledge patterns under four mixes: balanced, a flood against a mostly stalled consumer that keeps the stage full, full streaming with both handshakes held high, and a drain with no new input. The balanced mix reaches every state transition. The flood shows whether the second slot holds the in-flight word without overwriting the head. Streaming shows whether the one-item state sustains one word per cycle while swapping slots. The drain shows whether the stage returns cleanly to empty. In every cycle `out_ack` is also flipped between samples to show that `in_ack` does not follow it.

// File: rtl/elastic_pair_pkg.sv
package elastic_pair_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY  = 3'd0,
    ST_ONE_A  = 3'd1,  // one word, held in slot 0
    ST_ONE_B  = 3'd2,  // one word, held in slot 1
    ST_FULL_A = 3'd3,  // two words, oldest in slot 0
    ST_FULL_B = 3'd4   // two words, oldest in slot 1
  } pair_state_e;

  // Number of words held in a state.
  function automatic logic [1:0] f_count(input pair_state_e st);
    case (st)
      ST_ONE_A, ST_ONE_B:   f_count = 2'd1;
      ST_FULL_A, ST_FULL_B: f_count = 2'd2;
      default:              f_count = 2'd0;
    endcase
  endfunction

  // Upstream acknowledge: a pure decode of the state.
  function automatic logic f_can_take(input pair_state_e st);
    f_can_take = (f_count(st) != 2'd2);
  endfunction

  // Downstream request: anything held.
  function automatic logic f_has_word(input pair_state_e st);
    f_has_word = (f_count(st) != 2'd0);
  endfunction

  // Slot holding the oldest word (0 or 1).
  function automatic logic f_head_slot(input pair_state_e st);
    f_head_slot = (st == ST_ONE_B) || (st == ST_FULL_B);
  endfunction

  // Slot that receives the next accepted word.
  function automatic logic f_free_slot(input pair_state_e st);
    f_free_slot = (st == ST_ONE_A);
  endfunction

  // Transition function.
  function automatic pair_state_e f_next(input pair_state_e st,
                                         input logic in_req,
                                         input logic out_ack);
    f_next = st;
    case (st)
      ST_EMPTY: if (in_req) f_next = ST_ONE_A;
      ST_ONE_A: begin
        if (in_req && out_ack)       f_next = ST_ONE_B;
        else if (in_req)             f_next = ST_FULL_A;
        else if (out_ack)            f_next = ST_EMPTY;
      end
      ST_ONE_B: begin
        if (in_req && out_ack)       f_next = ST_ONE_A;
        else if (in_req)             f_next = ST_FULL_B;
        else if (out_ack)            f_next = ST_EMPTY;
      end
      ST_FULL_A: if (out_ack) f_next = ST_ONE_B;
      ST_FULL_B: if (out_ack) f_next = ST_ONE_A;
      default:   f_next = ST_EMPTY;
    endcase
  endfunction

endpackage

// File: rtl/elastic_pair_ctrl.sv
module elastic_pair_ctrl
  import elastic_pair_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  input  logic             out_ack,
  output logic             in_ack,
  output logic             out_req,
  output logic             head_sel,
  output logic [SLOTS-1:0] load_en
);

  pair_state_e state_q, state_d;
  logic        in_xfer;
  logic        out_xfer;

  assign in_ack   = f_can_take(state_q);
  assign out_req  = f_has_word(state_q);
  assign head_sel = f_head_slot(state_q);
  assign in_xfer  = in_req && in_ack;
  assign out_xfer = out_req && out_ack;

  always_comb begin
    state_d = f_next(state_q, in_req, out_ack);
  end

  always_comb begin
    load_en = '0;
    if (in_xfer) load_en[f_free_slot(state_q)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_EMPTY;
    else        state_q <= state_d;
  end

  AST_FULL_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ack |-> out_req); // R2
  AST_EMPTY_IMPLIES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |-> in_ack); // R3
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_en)); // R9
  AST_LOAD_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_en) |-> (in_req && in_ack)); // R9
  AST_STALL_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req); // R6
  AST_STREAM_KEEPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && out_xfer) |=> in_ack); // R8
  AST_COUNT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !out_xfer) |=> (f_count(state_q) == $past(f_count(state_q)) + 2'd1)); // R5

endmodule

// File: rtl/elastic_pair_slots.sv
module elastic_pair_slots #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS-1:0]  load_en,
  input  logic              head_sel,
  input  logic [DATA_W-1:0] in_dat,
  output logic [DATA_W-1:0] out_dat
);

  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[g] <= '0;
      else if (load_en[g]) slot_q[g] <= in_dat;
    end
  end

  assign out_dat = head_sel ? slot_q[1] : slot_q[0];

endmodule

// File: rtl/elastic_pair_stage.sv
module elastic_pair_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_dat,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_dat
);

  localparam int SLOTS = 2;

  logic             head_sel;
  logic [SLOTS-1:0] load_en;

  elastic_pair_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .out_ack  (out_ack),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .head_sel (head_sel),
    .load_en  (load_en)
  );

  elastic_pair_slots #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .head_sel (head_sel),
    .in_dat   (in_dat),
    .out_dat  (out_dat)
  );

  AST_STALL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> $stable(out_dat)); // R6
  AST_EMPTY_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_req && in_req) |=> (out_req && out_dat == $past(in_dat))); // R4

endmodule

// File: tb/test_elastic_pair_stage.sv
module test_elastic_pair_stage;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_req = 1'b0;
  logic          in_ack;
  logic [DW-1:0] in_dat = '0;
  logic          out_req;
  logic          out_ack = 1'b0;
  logic [DW-1:0] out_dat;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  elastic_pair_stage #(.DATA_W(DW)) i_elastic_pair_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_req  (in_req),
    .in_ack  (in_ack),
    .in_dat  (in_dat),
    .out_req (out_req),
    .out_ack (out_ack),
    .out_dat (out_dat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare with the model, step the model at posedge.
  task automatic step(input int p_in, input int p_out);
    logic ack_before;
    logic in_x, out_x;
    @(negedge clk);
    in_req  = ($urandom_range(99) < p_in);
    out_ack = ($urandom_range(99) < p_out);
    in_dat  = DW'($urandom);
    #1;
    check("R3 out_req", out_req, model_q.size() > 0);
    check("R2 in_ack", in_ack, model_q.size() < 2);
    if (model_q.size() > 0) check("R5 order", out_dat, model_q[0]);
    // R7: flip out_ack inside the cycle; in_ack must not move
    ack_before = in_ack;
    out_ack = ~out_ack;
    #1;
    check("R7 ack isolation", in_ack, ack_before);
    out_ack = ~out_ack;
    #1;
    in_x  = in_req && (model_q.size() < 2);
    out_x = out_ack && (model_q.size() > 0);
    @(posedge clk);
    if (out_x) void'(model_q.pop_front());
    if (in_x)  model_q.push_back(in_dat);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values, during and after reset
    #(CLK_PERIOD*2 + 1);
    check("R1 out_req in reset", out_req, 1'b0);
    check("R1 in_ack in reset", in_ack, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_req after reset", out_req, 1'b0);
    check("R1 in_ack after reset", in_ack, 1'b1);

    // R4: one word into the empty stage appears after one edge
    in_req = 1'b1; in_dat = 16'hA5C3; out_ack = 1'b0;
    @(negedge clk);
    in_req = 1'b0; in_dat = 16'h0000;
    #1;
    check("R4 latency valid", out_req, 1'b1);
    check("R4 latency data", out_dat, 16'hA5C3);
    // R9: data changes while idle do not disturb the held word
    in_dat = 16'hFFFF;
    @(negedge clk);
    check("R9 idle data ignored", out_dat, 16'hA5C3);
    // fill, then offer a rejected word with in_ack low
    in_req = 1'b1; in_dat = 16'h1234;
    @(negedge clk);
    check("R2 full", in_ack, 1'b0);
    in_dat = 16'hDEAD;
    @(negedge clk);
    in_req = 1'b0;
    check("R6 stall data", out_dat, 16'hA5C3);
    out_ack = 1'b1;
    @(negedge clk);
    check("R9 rejected word ignored", out_dat, 16'h1234);
    @(negedge clk);
    check("R5 drained", out_req, 1'b0);
    out_ack = 1'b0;

    // Random phases against the reference queue
    for (int i = 0; i < 2000; i++) step(50, 50);
    for (int i = 0; i < 1500; i++) step(90, 20);
    for (int i = 0; i < 1500; i++) step(20, 90);

    // R8: full streaming
    for (int i = 0; i < 500; i++) begin
      step(100, 100);
      if (model_q.size() == 1) check("R8 stream ack", in_ack, 1'b1);
    end
    for (int i = 0; i < 10; i++) step(0, 100);
    #1;
    check("R5 final empty", out_req, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule